// File: doc/BRIEF.md
# Key-Protected System Control Register Bank

This block is a bank of 32-bit control words behind a simple word-wide read/write port. System software uses it to assert and release block resets and clock stops, to look at and adjust the straps, and to read identity and revision words. The reset and clock-stop controls come in pairs of addresses. Writing ones at the first address of a pair sets bits, and writing ones at the next address clears the same bits. Software never needs a read-modify-write sequence.

An unlock word turns any value written to it into a single match flag, and the flag is brought out as a port. Each of the two strap words has a protect word. While its protect word is nonzero, a strap can no longer gain bits, but it can still lose them through its clear address. One word returns a new pseudo-random value on every read. The PLL extension words always report lock. At reset, most words take a fixed table value, and the revision, strap and key words take their values from input pins.

Top module: `sysctl_regbank`

## Requirements
- R1: A write to offset 0x000 stores 1 when the data equals the UNLOCK_KEY parameter and 0 otherwise. Reading 0x000 returns that 0 or 1, and `unlocked_o` is 1 exactly when the stored word is nonzero.
- R2: A write to a set address (0x040, 0x050, 0x080, 0x090) ORs the written data into that word.
- R3: A write to a clear address (0x044, 0x054, 0x084, 0x094) clears, in the word at the address 4 below it, every bit that is 1 in the data. Other bits are kept.
- R4: A write to a strap word (0x500 or 0x510) ORs the data in, but only while its protect word (0x508 or 0x518 respectively) reads zero. Otherwise the write is dropped.
- R5: A write to a strap clear address (0x504 or 0x514) clears the written one-bits in the strap word 4 below it, whatever the protect word holds.
- R6: Writes to 0x004, 0x014, 0x540, 0x5B0 and 0x5B4 leave the stored value unchanged.
- R7: A read of 0x204, 0x224 or 0x244 returns the stored word with bit 31 forced to 1. Writes to these addresses store the data as written.
- R8: Each read of 0x540 returns the next state of a 32-bit generator. The first read after reset returns the SEED parameter, every value returned is nonzero, and consecutive reads differ.
- R9: Reset loads 0x000 from `key_strap_i`, 0x004 from the REV_FIXED parameter, 0x014 from `rev_i`, 0x500 from `strap_a_i` and 0x510 from `strap_b_i`. It loads 0x040=0000FF00, 0x050=0F0F0000, 0x080=FFFF0000, 0x090=00FF00FF, 0x204=00001234, 0x5B0=C0DE0001 and 0x5B4=C0DE0002 (hex). Every other word resets to 0.
- R10: An access with address bits [1:0] nonzero, or at a word index of NUM_WORDS (default 368, so from 0x5C0) or above, reads 0 and writes nothing.
- R11: Every other in-range aligned offset is plain storage that reads back the last value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel_i | input | 1 | Access request this cycle |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W (12) | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the same cycle as the read request |
| rev_i | input | 32 | Revision value loaded at reset into 0x014 |
| strap_a_i | input | 32 | Reset value of strap word 0x500 |
| strap_b_i | input | 32 | Reset value of strap word 0x510 |
| key_strap_i | input | 32 | Reset value of the unlock word |
| unlocked_o | output | 1 | Unlock word is nonzero |

## Verification
The assertions check on every cycle that:
- set writes never drop a bit,
- a protected strap write and a write to an identity word leave the word unchanged,
- PLL reads carry bit 31,
- invalid reads return zero,
- the generator never stalls or reaches zero.

Only the bench scenarios can show the exact arithmetic of each set/clear pair, the reset table, the unlock match flag, the path from a clear address to the word below it, and read-back of plain storage. The bench does this with sweeps and a running model of each word.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  localparam int unsigned W_KEY      = 'h000 >> 2;
  localparam int unsigned W_REV_A    = 'h004 >> 2;
  localparam int unsigned W_REV_B    = 'h014 >> 2;
  localparam int unsigned W_RSET_0   = 'h040 >> 2;
  localparam int unsigned W_RSET_1   = 'h050 >> 2;
  localparam int unsigned W_CSET_0   = 'h080 >> 2;
  localparam int unsigned W_CSET_1   = 'h090 >> 2;
  localparam int unsigned W_PLLX_0   = 'h204 >> 2;
  localparam int unsigned W_PLLX_1   = 'h224 >> 2;
  localparam int unsigned W_PLLX_2   = 'h244 >> 2;
  localparam int unsigned W_STRAP_A  = 'h500 >> 2;
  localparam int unsigned W_STRAP_B  = 'h510 >> 2;
  localparam int unsigned W_RNG      = 'h540 >> 2;
  localparam int unsigned W_ID_0     = 'h5B0 >> 2;
  localparam int unsigned W_ID_1     = 'h5B4 >> 2;
  localparam int unsigned LOCK_DIST  = 2;

  typedef enum logic [3:0] {
    K_VOID, K_KEY, K_SET, K_CLR, K_STRAP_SET, K_STRAP_CLR,
    K_FIXED, K_RNG, K_PLL, K_PLAIN
  } acc_kind_e;

  // Constant part of the reset image; pin-loaded words are handled in the top.
  function automatic logic [31:0] table_word(int unsigned w);
    logic [31:0] v;
    v = '0;
    if (w == W_RSET_0)      v = 32'h0000_FF00;
    else if (w == W_RSET_1) v = 32'h0F0F_0000;
    else if (w == W_CSET_0) v = 32'hFFFF_0000;
    else if (w == W_CSET_1) v = 32'h00FF_00FF;
    else if (w == W_PLLX_0) v = 32'h0000_1234;
    else if (w == W_ID_0)   v = 32'hC0DE_0001;
    else if (w == W_ID_1)   v = 32'hC0DE_0002;
    return v;
  endfunction

endpackage

// File: rtl/sysctl_lfsr.sv
module sysctl_lfsr #(
  parameter int          W    = 32,
  parameter logic [W-1:0] TAPS = 32'hA300_0000,
  parameter logic [W-1:0] SEED = 32'h1ACE_B00C
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step_i,
  output logic [W-1:0] value_o
);

  logic [W-1:0] state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (step_i) state_d = {1'b0, state_q[W-1:1]} ^ (state_q[0] ? TAPS : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEED;
    else if (step_i) state_q <= state_d;
  end

  assign value_o = state_q;

  a_r8_never_zero: assert property (@(posedge clk) disable iff (!rst_n)
    value_o != '0);
  a_r8_step_moves: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |=> value_o != $past(value_o));

endmodule

// File: rtl/sysctl_decode.sv
module sysctl_decode
  import sysctl_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int NUM_WORDS = 368,
  parameter int IDX_W     = $clog2(NUM_WORDS)
) (
  input  logic [ADDR_W-1:0] addr_i,
  output acc_kind_e         kind_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [IDX_W-1:0]  tgt_o
);

  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  int unsigned       widx;

  always_comb begin
    word   = addr_i[ADDR_W-1:2];
    widx   = 32'(word);
    idx_o  = word[IDX_W-1:0];
    kind_o = K_PLAIN;
    if (addr_i[1:0] != 2'b00 || widx >= NUM_WORDS) begin
      kind_o = K_VOID;
    end else begin
      case (widx)
        W_KEY:                                  kind_o = K_KEY;
        W_RSET_0, W_RSET_1, W_CSET_0, W_CSET_1: kind_o = K_SET;
        W_RSET_0 + 1, W_RSET_1 + 1,
        W_CSET_0 + 1, W_CSET_1 + 1:             kind_o = K_CLR;
        W_STRAP_A, W_STRAP_B:                   kind_o = K_STRAP_SET;
        W_STRAP_A + 1, W_STRAP_B + 1:           kind_o = K_STRAP_CLR;
        W_REV_A, W_REV_B, W_ID_0, W_ID_1:       kind_o = K_FIXED;
        W_RNG:                                  kind_o = K_RNG;
        W_PLLX_0, W_PLLX_1, W_PLLX_2:           kind_o = K_PLL;
        default:                                kind_o = K_PLAIN;
      endcase
    end
    // clear addresses act on the word just below them
    tgt_o = (kind_o == K_CLR || kind_o == K_STRAP_CLR) ? idx_o - 1'b1 : idx_o;
  end

endmodule

// File: rtl/sysctl_regbank.sv
module sysctl_regbank
  import sysctl_pkg::*;
#(
  parameter int          ADDR_W     = 12,
  parameter int          NUM_WORDS  = 368,
  parameter logic [31:0] UNLOCK_KEY = 32'h5AFE_C0DE,
  parameter logic [31:0] REV_FIXED  = 32'h0A01_0001,
  parameter logic [31:0] SEED       = 32'h1ACE_B00C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  input  logic [31:0]       rev_i,
  input  logic [31:0]       strap_a_i,
  input  logic [31:0]       strap_b_i,
  input  logic [31:0]       key_strap_i,
  output logic              unlocked_o
);

  localparam int          IDX_W    = $clog2(NUM_WORDS);
  localparam logic [31:0] LOCK_BIT = 32'h8000_0000;

  logic [31:0]      bank [NUM_WORDS];
  acc_kind_e        kind;
  logic [IDX_W-1:0] idx, tgt;
  logic [31:0]      rng_val, guard, rd_data;
  logic             wr_req, rd_req, rng_step;
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic [31:0]      wr_val;

  sysctl_decode #(.ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W)) u_dec (
    .addr_i (bus_addr_i),
    .kind_o (kind),
    .idx_o  (idx),
    .tgt_o  (tgt)
  );

  assign wr_req   = bus_sel_i && bus_wr_i;
  assign rd_req   = bus_sel_i && !bus_wr_i;
  assign rng_step = rd_req && (kind == K_RNG);

  sysctl_lfsr #(.W(32), .SEED(SEED)) u_rng (
    .clk     (clk),
    .rst_n   (rst_n),
    .step_i  (rng_step),
    .value_o (rng_val)
  );

  // protect word belonging to the strap being addressed
  assign guard = (idx == IDX_W'(W_STRAP_A)) ? bank[W_STRAP_A + LOCK_DIST]
                                            : bank[W_STRAP_B + LOCK_DIST];

  // next-state: one word updated per cycle at most
  always_comb begin
    wr_en  = 1'b0;
    wr_idx = tgt;
    wr_val = bus_wdata_i;
    if (wr_req) begin
      unique case (kind)
        K_KEY: begin
          wr_en  = 1'b1;
          wr_val = {31'b0, bus_wdata_i == UNLOCK_KEY};
        end
        K_SET: begin
          wr_en  = 1'b1;
          wr_val = bank[tgt] | bus_wdata_i;
        end
        K_STRAP_SET: begin
          wr_en  = (guard == '0);
          wr_val = bank[tgt] | bus_wdata_i;
        end
        K_CLR, K_STRAP_CLR: begin
          wr_en  = 1'b1;
          wr_val = bank[tgt] & ~bus_wdata_i;
        end
        K_PLL, K_PLAIN: wr_en = 1'b1;
        K_VOID, K_FIXED, K_RNG: wr_en = 1'b0;
        default: wr_en = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_WORDS; i++) begin
        if (i == W_KEY)          bank[i] <= key_strap_i;
        else if (i == W_REV_A)   bank[i] <= REV_FIXED;
        else if (i == W_REV_B)   bank[i] <= rev_i;
        else if (i == W_STRAP_A) bank[i] <= strap_a_i;
        else if (i == W_STRAP_B) bank[i] <= strap_b_i;
        else                     bank[i] <= table_word(unsigned'(i));
      end
    end else if (wr_en) begin
      bank[wr_idx] <= wr_val;
    end
  end

  // read path
  always_comb begin
    rd_data = '0;
    if (rd_req) begin
      unique case (kind)
        K_VOID:  rd_data = '0;
        K_RNG:   rd_data = rng_val;
        K_PLL:   rd_data = bank[idx] | LOCK_BIT;
        default: rd_data = bank[idx];
      endcase
    end
  end

  assign bus_rdata_o = rd_data;
  assign unlocked_o  = (bank[W_KEY] != '0);

  a_r1_key_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && bus_addr_i == '0) |=> unlocked_o == $past(bus_wdata_i == UNLOCK_KEY));
  a_r2_set_keeps_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && kind == K_SET) |=>
      (bank[$past(idx)] & $past(bank[idx])) == $past(bank[idx]));
  a_r4_protected_strap: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && kind == K_STRAP_SET && guard != '0) |=>
      bank[$past(idx)] == $past(bank[idx]));
  a_r6_fixed_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && kind == K_FIXED) |=> bank[$past(idx)] == $past(bank[idx]));
  a_r7_pll_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && kind == K_PLL) |-> bus_rdata_o[31]);
  a_r10_void_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && (bus_addr_i[1:0] != 2'b00)) |-> bus_rdata_o == '0);

endmodule

// File: tb/sysctl_regbank_test.sv
module sysctl_regbank_test;

  localparam logic [31:0] KEY  = 32'h5AFE_C0DE;
  localparam logic [31:0] REVF = 32'h0A01_0001;
  localparam logic [31:0] SEED = 32'h1ACE_B00C;
  localparam logic [31:0] REVI = 32'h0000_00A3;
  localparam logic [31:0] SA   = 32'h0000_0F01;
  localparam logic [31:0] SB   = 32'h8000_0010;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sel = 1'b0, wr = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic unlocked;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sysctl_regbank uut (
    .clk(clk), .rst_n(rst_n), .bus_sel_i(sel), .bus_wr_i(wr),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .rev_i(REVI), .strap_a_i(SA), .strap_b_i(SB), .key_strap_i(32'h0),
    .unlocked_o(unlocked)
  );

  function automatic logic [31:0] exp_table(int a);
    case (a)
      'h040: return 32'h0000_FF00;
      'h050: return 32'h0F0F_0000;
      'h080: return 32'hFFFF_0000;
      'h090: return 32'h00FF_00FF;
      'h204: return 32'h0000_1234;
      'h5B0: return 32'hC0DE_0001;
      'h5B4: return 32'hC0DE_0002;
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_word(int a, logic [31:0] d);
    @(negedge clk); sel = 1'b1; wr = 1'b1; addr = 12'(a); wdata = d;
    @(negedge clk); sel = 1'b0; wr = 1'b0;
  endtask

  task automatic rd_word(int a, output logic [31:0] v);
    @(negedge clk); sel = 1'b1; wr = 1'b0; addr = 12'(a);
    #1 v = rdata;
    @(negedge clk); sel = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, e, r0, r1, r2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R9 reset image
    check("R9 unlocked", {31'b0, unlocked}, 32'h0);
    rd_word('h000, v); check("R9 key", v, 32'h0);
    rd_word('h004, v); check("R9 rev fixed", v, REVF);
    rd_word('h014, v); check("R9 rev pin", v, REVI);
    rd_word('h500, v); check("R9 strap a", v, SA);
    rd_word('h510, v); check("R9 strap b", v, SB);
    foreach (exp_table_list[k]) begin
      rd_word(exp_table_list[k], v);
      e = exp_table(exp_table_list[k]);
      if (exp_table_list[k] == 'h204) e = e | 32'h8000_0000;
      check("R9 table", v, e);
    end

    // R1 unlock word
    wr_word('h000, KEY ^ 32'h1);
    rd_word('h000, v); check("R1 wrong key", v, 32'h0);
    check("R1 flag low", {31'b0, unlocked}, 32'h0);
    wr_word('h000, KEY);
    rd_word('h000, v); check("R1 right key", v, 32'h1);
    check("R1 flag high", {31'b0, unlocked}, 32'h1);
    wr_word('h000, 32'h1);
    check("R1 relock", {31'b0, unlocked}, 32'h0);

    // R2 / R3 set-clear pairs, several patterns each
    for (int p = 0; p < 4; p++) begin
      int base;
      base = (p == 0) ? 'h040 : (p == 1) ? 'h050 : (p == 2) ? 'h080 : 'h090;
      e = exp_table(base);
      for (int k = 0; k < 4; k++) begin
        logic [31:0] s, c;
        s = 32'h0101_0101 << (k * 2);
        c = 32'hF000_000F >> k;
        wr_word(base, s); e = e | s;
        rd_word(base, v); check("R2 set", v, e);
        wr_word(base + 4, c); e = e & ~c;
        rd_word(base, v); check("R3 clear", v, e);
      end
    end

    // R4 / R5 straps and protect words
    for (int p = 0; p < 2; p++) begin
      int base;
      base = (p == 0) ? 'h500 : 'h510;
      e = (p == 0) ? SA : SB;
      wr_word(base, 32'h0000_00F0); e = e | 32'h0000_00F0;
      rd_word(base, v); check("R4 strap set open", v, e);
      wr_word(base + 8, 32'h1);
      wr_word(base, 32'h0F00_0000);
      rd_word(base, v); check("R4 strap set protected", v, e);
      wr_word(base + 4, 32'h0000_0030); e = e & ~32'h0000_0030;
      rd_word(base, v); check("R5 strap clear protected", v, e);
      wr_word(base + 8, 32'h0);
      wr_word(base, 32'h0F00_0000); e = e | 32'h0F00_0000;
      rd_word(base, v); check("R4 strap set reopened", v, e);
    end

    // R6 read-only words
    wr_word('h004, 32'hDEAD_BEEF); rd_word('h004, v); check("R6 rev a", v, REVF);
    wr_word('h014, 32'hDEAD_BEEF); rd_word('h014, v); check("R6 rev b", v, REVI);
    wr_word('h5B0, 32'h0);         rd_word('h5B0, v); check("R6 id0", v, 32'hC0DE_0001);
    wr_word('h5B4, 32'h0);         rd_word('h5B4, v); check("R6 id1", v, 32'hC0DE_0002);

    // R7 PLL lock bit
    wr_word('h224, 32'h0000_0012);
    rd_word('h224, v); check("R7 pll written", v, 32'h8000_0012);
    rd_word('h244, v); check("R7 pll zero", v, 32'h8000_0000);

    // R8 random word
    rd_word('h540, r0); check("R8 first is seed", r0, SEED);
    wr_word('h540, r0);
    rd_word('h540, r1); check("R8 differs 1", {31'b0, r1 == r0}, 32'h0);
    rd_word('h540, r2); check("R8 differs 2", {31'b0, r2 == r1}, 32'h0);
    check("R8 nonzero", {31'b0, r2 == 32'h0}, 32'h0);

    // R11 plain storage sweep
    for (int a = 'h300; a < 'h400; a += 4) wr_word(a, 32'h9E37_79B9 * a);
    for (int a = 'h300; a < 'h400; a += 4) begin
      rd_word(a, v); check("R11 plain", v, 32'h9E37_79B9 * a);
    end

    // R10 invalid accesses
    rd_word('h5C0, v); check("R10 beyond range", v, 32'h0);
    rd_word('hFFC, v); check("R10 top", v, 32'h0);
    rd_word('h302, v); check("R10 misaligned read", v, 32'h0);
    wr_word('h301, 32'h1234_5678);
    rd_word('h300, v); check("R10 misaligned write dropped", v, 32'h9E37_79B9 * 'h300);
    wr_word('h5C0, 32'hFFFF_FFFF);
    rd_word('h5C0, v); check("R10 oob write", v, 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  int exp_table_list [7] = '{'h040, 'h050, 'h080, 'h090, 'h204, 'h5B0, 'h5B4};

endmodule